// File: doc/BRIEF.md
# Shared Level Interrupt and Channel-Check Status

This block sits on an add-in card and turns the card's internal event strobes into one level-sensitive interrupt request. Other cards can share the same request line. Each event cause has its own pending flag. The request stays asserted for as long as any pending cause is not masked. Driver software polls the pending flags to learn whether this card is the one asking for service. It then clears the flags it has serviced by writing ones to them. An event that arrives while the request is already asserted is recorded in its own flag, so it is never lost.

A second path reports fatal errors. A one-cycle error strobe sets a sticky channel-check flag, and the active-low channel-check line is pulled low. Both stay that way until software writes a one to the flag's clear bit. No other event clears them. Neither output drives a logic level of its own. Each is a registered pull-down enable, so the board can wire-OR the lines with other cards. A simple synchronous register port gives software access to the pending flags, a per-cause mask, the channel-check flag and a read-only summary. A parameter selects the event input form: pulse strobes or level signals with edge detection.

Top module: `irq_chk_status`

## Requirements
- R1: After reset, every pending flag, every mask bit and the channel-check flag read 0, and both `irq_oe_o` and `chk_oe_o` are 0.
- R2: A 1 on `evt_i[i]` in a clock cycle sets pending flag i at that clock edge. The pending flags read back at register 0, with bit i holding cause i.
- R3: `irq_oe_o` is 1 in the cycle after any pending flag is 1 while its mask bit is 0. It stays 1 as long as such a flag remains. It drops one cycle after the last unmasked flag is cleared.
- R4: A write to register 0 clears each pending flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R5: If an event for cause i arrives in the same cycle as a write that clears flag i, the event wins and the flag stays 1.
- R6: Register 1 is a read/write mask of `DATA_W` bits. Mask bit i set to 1 keeps cause i from driving `irq_oe_o`, but flag i still sets and still reads back at register 0.
- R7: A 1 on `err_i` sets the channel-check flag, which reads as bit 0 of register 2. `chk_oe_o` is 1 from the next cycle on.
- R8: The channel-check flag is cleared only by a write to register 2 with data bit 0 set. An error in that same cycle wins. Writes to other registers, and a write of 0 to bit 0, leave the flag set.
- R9: Register 3 is read-only. Bit 0 is 1 when any unmasked pending flag is set, and bit 1 is the channel-check flag. Writes to register 3 change nothing. Addresses 4 and above read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_SRC | Interrupt cause strobes (pulse mode) or levels (edge mode) |
| err_i | input | 1 | Fatal error strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data for the current address |
| irq_oe_o | output | 1 | Pull-down enable for the shared interrupt line |
| chk_oe_o | output | 1 | Pull-down enable for the active-low channel-check line |

## Verification
Two functions can act on the same flag in one cycle: a new event setting it and a software write-one clearing it. The same holds for an error strobe and a channel-check clear. Directed steps drive the event, or the error, together with the matching clear. After that edge the bench reads the flag back and checks that it is still 1. Constrained random steps then issue these collisions at random. Each read and each output enable is compared against a bench model in which a set always wins over a clear.

// File: rtl/irq_chk_pkg.sv
package irq_chk_pkg;

   typedef enum logic [1:0] {
      REG_PEND = 2'd0,
      REG_MASK = 2'd1,
      REG_CHK  = 2'd2,
      REG_SUM  = 2'd3
   } reg_sel_e;

   localparam int unsigned CHK_CLR_BIT = 0;
   localparam int unsigned SUM_SRC_BIT = 0;
   localparam int unsigned SUM_CHK_BIT = 1;

   localparam int unsigned EVT_PULSE = 0;
   localparam int unsigned EVT_EDGE  = 1;

   function automatic reg_sel_e to_sel(input logic [1:0] low_addr);
      return reg_sel_e'(low_addr);
   endfunction

endpackage

// File: rtl/irq_evt_edge.sv
module irq_evt_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   output logic pulse_o
);
   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= 1'b0;
      else        lvl_q <= lvl_i;
   end

   assign pulse_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q_d;

   always_comb begin
      q_d = q_o;
      if (clr_i) q_d = 1'b0;
      if (set_i) q_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= q_d;
   end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
   import irq_chk_pkg::*;
#(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic               chk_i,
   input  logic               src_active_i,
   output logic [NUM_SRC-1:0] pend_clr_o,
   output logic               chk_clr_o,
   output logic [DATA_W-1:0]  mask_o,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int unsigned PAD_W = DATA_W - NUM_SRC;

   logic     hit;
   reg_sel_e sel;

   generate
      if (ADDR_W > 2) begin : g_wide_addr
         assign hit = (addr_i[ADDR_W-1:2] == '0);
      end else begin : g_narrow_addr
         assign hit = 1'b1;
      end
   endgenerate

   assign sel = to_sel(addr_i[1:0]);

   logic wr_pend, wr_mask, wr_chk;
   assign wr_pend = wr_i && hit && (sel == REG_PEND);
   assign wr_mask = wr_i && hit && (sel == REG_MASK);
   assign wr_chk  = wr_i && hit && (sel == REG_CHK);

   assign pend_clr_o = wr_pend ? wdata_i[NUM_SRC-1:0] : '0;
   assign chk_clr_o  = wr_chk & wdata_i[CHK_CLR_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_o <= '0;
      else if (wr_mask) mask_o <= wdata_i;
   end

   logic [DATA_W-1:0] pend_ext;
   generate
      if (PAD_W > 0) begin : g_pad
         assign pend_ext = {{PAD_W{1'b0}}, pend_i};
      end else begin : g_nopad
         assign pend_ext = pend_i;
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (hit) begin
         unique case (sel)
            REG_PEND: rdata_o = pend_ext;
            REG_MASK: rdata_o = mask_o;
            REG_CHK:  rdata_o[CHK_CLR_BIT] = chk_i;
            REG_SUM: begin
               rdata_o[SUM_SRC_BIT] = src_active_i;
               rdata_o[SUM_CHK_BIT] = chk_i;
            end
            default:  rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic assert_i,
   output logic oe_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_o <= 1'b0;
      else        oe_o <= assert_i;
   end
endmodule

// File: rtl/irq_chk_status.sv
module irq_chk_status
   import irq_chk_pkg::*;
#(
   parameter int unsigned NUM_SRC  = 4,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned EVT_MODE = EVT_PULSE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] evt_i,
   input  logic               err_i,
   input  logic               reg_wr_i,
   input  logic [ADDR_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0]  reg_wdata_i,
   output logic [DATA_W-1:0]  reg_rdata_o,
   output logic               irq_oe_o,
   output logic               chk_oe_o
);
   generate
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("NUM_SRC must be between 1 and DATA_W");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must be at least 2");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (EVT_MODE != EVT_PULSE && EVT_MODE != EVT_EDGE) begin : g_bad_mode
         $error("EVT_MODE must select pulse or edge input");
      end
   endgenerate

   logic [NUM_SRC-1:0] evt_eff;
   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] pend_clr;
   logic [DATA_W-1:0]  mask_q;
   logic               chk_q;
   logic               chk_clr;
   logic               src_active;

   generate
      if (EVT_MODE == EVT_EDGE) begin : g_edge_in
         for (genvar i = 0; i < NUM_SRC; i++) begin : g_det
            irq_evt_edge u_det (
               .clk     (clk),
               .rst_n   (rst_n),
               .lvl_i   (evt_i[i]),
               .pulse_o (evt_eff[i])
            );
         end
      end else begin : g_pulse_in
         assign evt_eff = evt_i;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_pend
         irq_pend_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_eff[i]),
            .clr_i (pend_clr[i]),
            .q_o   (pend_q[i])
         );
      end
   endgenerate

   irq_pend_cell u_chk (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (err_i),
      .clr_i (chk_clr),
      .q_o   (chk_q)
   );

   assign src_active = |(pend_q & ~mask_q[NUM_SRC-1:0]);

   irq_reg_port #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_i         (reg_wr_i),
      .addr_i       (reg_addr_i),
      .wdata_i      (reg_wdata_i),
      .pend_i       (pend_q),
      .chk_i        (chk_q),
      .src_active_i (src_active),
      .pend_clr_o   (pend_clr),
      .chk_clr_o    (chk_clr),
      .mask_o       (mask_q),
      .rdata_o      (reg_rdata_o)
   );

   irq_line_drv u_irq_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .assert_i (src_active),
      .oe_o     (irq_oe_o)
   );

   irq_line_drv u_chk_drv (
      .clk      (clk),
      .rst_n    (rst_n),
      .assert_i (chk_q),
      .oe_o     (chk_oe_o)
   );
endmodule

// File: rtl/irq_chk_sva.sv
module irq_chk_sva #(
   parameter int unsigned NUM_SRC = 4,
   parameter int unsigned ADDR_W  = 4,
   parameter int unsigned DATA_W  = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] evt_eff,
   input logic               err_i,
   input logic               reg_wr_i,
   input logic [ADDR_W-1:0]  reg_addr_i,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [NUM_SRC-1:0] pend_q,
   input logic [DATA_W-1:0]  mask_q,
   input logic               chk_q,
   input logic               irq_oe_o,
   input logic               chk_oe_o
);
   logic wr_pend, wr_chk_clr;
   assign wr_pend    = reg_wr_i && (reg_addr_i == ADDR_W'(0));
   assign wr_chk_clr = reg_wr_i && (reg_addr_i == ADDR_W'(2)) && reg_wdata_i[0];

   // R2 and R5: an event always leaves its flag set, whatever the write
   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_eff != '0) |=> ((pend_q & $past(evt_eff)) == $past(evt_eff)));

   p_evt_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && ((reg_wdata_i[NUM_SRC-1:0] & evt_eff) != '0))
      |=> ((pend_q & $past(reg_wdata_i[NUM_SRC-1:0] & evt_eff)) != '0));

   p_w1c_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_pend && ((reg_wdata_i[NUM_SRC-1:0] & ~evt_eff) != '0))
      |=> ((pend_q & $past(reg_wdata_i[NUM_SRC-1:0] & ~evt_eff)) == '0));

   p_irq_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_oe_o) |-> ($past(pend_q) != '0));

   p_irq_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend_q & ~mask_q[NUM_SRC-1:0]) == '0) |=> !irq_oe_o);

   p_chk_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      err_i |=> (chk_q ##1 chk_oe_o));

   p_chk_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_q && !wr_chk_clr) |=> chk_q);
endmodule

bind irq_chk_status irq_chk_sva #(
   .NUM_SRC (NUM_SRC),
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W)
) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_eff     (evt_eff),
   .err_i       (err_i),
   .reg_wr_i    (reg_wr_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .pend_q      (pend_q),
   .mask_q      (mask_q),
   .chk_q       (chk_q),
   .irq_oe_o    (irq_oe_o),
   .chk_oe_o    (chk_oe_o)
);

// File: tb/sim_irq_chk_status.sv
`timescale 1ns/1ps
module sim_irq_chk_status;
   localparam int N  = 4;
   localparam int AW = 4;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  evt = '0;
   logic          err = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq_oe, chk_oe;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [N-1:0]  m_pend;
   logic [DW-1:0] m_mask;
   logic          m_chk, m_irq, m_chk_oe;

   always #5 clk = ~clk;

   irq_chk_status #(.NUM_SRC(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
      .clk (clk), .rst_n (rst_n), .evt_i (evt), .err_i (err),
      .reg_wr_i (wr), .reg_addr_i (addr), .reg_wdata_i (wdata),
      .reg_rdata_o (rdata), .irq_oe_o (irq_oe), .chk_oe_o (chk_oe)
   );

   function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
      logic [DW-1:0] r = '0;
      case (a)
         4'd0: r[N-1:0] = m_pend;
         4'd1: r = m_mask;
         4'd2: r[0] = m_chk;
         4'd3: begin r[0] = |(m_pend & ~m_mask[N-1:0]); r[1] = m_chk; end
         default: r = '0;
      endcase
      return r;
   endfunction

   function automatic string rd_tag(input logic [AW-1:0] a);
      case (a)
         4'd0: return "R2";
         4'd1: return "R6";
         4'd2: return "R7";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tg);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tg, act, exp);
      end
   endtask

   // Starts at a falling edge; ends at the next falling edge.
   task automatic step(input logic [N-1:0] e, input logic r, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d, input string tg);
      logic [N-1:0] clr;
      evt = e; err = r; wr = w; addr = a; wdata = d;
      #1;
      check(rdata, m_read(a), {tg, "/", rd_tag(a)});
      @(posedge clk);
      m_irq    = |(m_pend & ~m_mask[N-1:0]);
      m_chk_oe = m_chk;
      clr      = (w && a == 4'd0) ? d[N-1:0] : '0;
      m_pend   = (m_pend & ~clr) | e;
      if (w && a == 4'd1) m_mask = d;
      m_chk    = (m_chk & ~(w && a == 4'd2 && d[0])) | r;
      @(negedge clk);
      check(irq_oe, m_irq, {tg, "/R3"});
      check(chk_oe, m_chk_oe, {tg, "/R7"});
   endtask

   task automatic idle_read(input logic [AW-1:0] a, input string tg);
      step('0, 1'b0, 1'b0, a, '0, tg);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      m_pend = '0; m_mask = '0; m_chk = 1'b0; m_irq = 1'b0; m_chk_oe = 1'b0;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: reset state visible at outputs and all registers
      check(irq_oe, 1'b0, "R1 irq_oe");
      check(chk_oe, 1'b0, "R1 chk_oe");
      rst_n = 1'b1;
      @(negedge clk);
      for (int a = 0; a < 4; a++) idle_read(AW'(a), "R1");

      // R2, R3: event sets flag, interrupt follows
      step(4'b0100, 1'b0, 1'b0, 4'd0, '0, "R2 set");
      idle_read(4'd0, "R2 read");
      check(irq_oe, 1'b1, "R3 asserted");
      // R5: event and clear of same flag in one cycle
      step(4'b0100, 1'b0, 1'b1, 4'd0, 8'h04, "R5 collide");
      idle_read(4'd0, "R5 still set");
      check(rdata[2], 1'b1, "R5 flag kept");
      // R4: write zero bits leave flag, then clear
      step('0, 1'b0, 1'b1, 4'd0, 8'h0B, "R4 other bits");
      idle_read(4'd0, "R4 kept");
      step('0, 1'b0, 1'b1, 4'd0, 8'h04, "R4 clear");
      idle_read(4'd0, "R4 cleared");
      check(irq_oe, 1'b0, "R3 dropped");

      // R6: masked cause keeps pending but no interrupt
      step('0, 1'b0, 1'b1, 4'd1, 8'hA2, "R6 mask");
      idle_read(4'd1, "R6 readback");
      step(4'b0010, 1'b0, 1'b0, 4'd0, '0, "R6 masked evt");
      idle_read(4'd0, "R6 pending");
      check(irq_oe, 1'b0, "R6 suppressed");
      step('0, 1'b0, 1'b1, 4'd1, 8'h00, "R6 unmask");
      idle_read(4'd3, "R9 summary");
      check(irq_oe, 1'b1, "R6 released");
      step('0, 1'b0, 1'b1, 4'd0, 8'hFF, "R4 clear all");

      // R7, R8: sticky channel check
      step('0, 1'b1, 1'b0, 4'd2, '0, "R7 err");
      idle_read(4'd2, "R7 flag");
      check(chk_oe, 1'b1, "R7 line");
      step('0, 1'b0, 1'b1, 4'd0, 8'hFF, "R8 wr pend");
      step('0, 1'b0, 1'b1, 4'd2, 8'hFE, "R8 wr zero");
      step('0, 1'b0, 1'b1, 4'd3, 8'hFF, "R9 wr sum");
      step('0, 1'b0, 1'b1, 4'd7, 8'hFF, "R9 wr hi");
      idle_read(4'd2, "R8 held");
      check(chk_oe, 1'b1, "R8 held line");
      step('0, 1'b1, 1'b1, 4'd2, 8'h01, "R8 collide");
      idle_read(4'd2, "R8 err wins");
      step('0, 1'b0, 1'b1, 4'd2, 8'h01, "R8 clear");
      idle_read(4'd3, "R9 after clear");
      check(chk_oe, 1'b0, "R8 released");
      idle_read(4'd9, "R9 unmapped");

      // Constrained random mix
      for (int k = 0; k < 600; k++) begin
         logic [N-1:0]  e = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
         logic          r = ($urandom_range(0, 15) == 0);
         logic          w = ($urandom_range(0, 2) == 0);
         logic [AW-1:0] a = ($urandom_range(0, 7) == 0) ? AW'($urandom) : AW'($urandom_range(0, 3));
         logic [DW-1:0] d = DW'($urandom);
         step(e, r, w, a, d, "rand");
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule